// File: doc/BRIEF.md
# Joinable Transmit/Receive FIFO Pair

This block sits between a bus-side register interface and a serial shifter for one state machine. It holds two word queues. The transmit queue is filled by bus writes and drained by shifter pulls. The receive queue is filled by shifter pushes and drained by bus reads. Each queue holds four 32-bit words in its normal setting.

A two-bit join setting can hand all of the capacity to one direction, making an eight-word queue, while the other direction is switched off. Any change of that setting empties both queues on the clock edge where the change is first seen. Any traffic offered in that same cycle is dropped.

The block reports empty, full and fill level for each queue. It raises a request line per direction for a DMA engine. It also keeps four sticky error flags. Each flag is cleared by writing 1 to its bit in the clear input.

The join logic is a small state machine with three states:
- MODE_DUPLEX: both queues are on, four words each.
- MODE_TX_DEEP: transmit holds eight words and receive is off.
- MODE_RX_DEEP: receive holds eight words and transmit is off.

The transition REJOIN fires on any edge where `cfg_join` differs from the registered copy. It flushes both queues and moves to the state decoded from the new setting. Otherwise the state holds (transition STAY).

Top module: `fifo_pair_join`

## Requirements
- R1: After reset both queues are empty, `fifo_level` is 0, `dbg_flags` is 0, the mode is duplex, `dreq_tx` is 1 and `dreq_rx` is 0.
- R2: In duplex mode (`cfg_join` = 2'b00) each queue holds at most 4 words and returns them in first-in first-out order. A queue reports full exactly at 4 words and empty exactly at 0.
- R3: A bus push while transmit is full is discarded, and it sets `dbg_flags[1]` (transmit overflow).
- R4: While receive is empty, `bus_rx_data` reads 0. A bus pop from an empty receive queue sets `dbg_flags[3]` (receive underflow).
- R5: While transmit is empty, `sh_tx_data` reads 0. A shifter pull from an empty transmit queue sets `dbg_flags[0]` (transmit stall).
- R6: A shifter push while receive is full is discarded, and it sets `dbg_flags[2]` (receive stall).
- R7: Each `dbg_flags` bit stays set until a cycle in which the matching `dbg_clr` bit is 1. If a new error and a clear of the same bit meet in one cycle, the bit stays set.
- R8: `cfg_join` bit 0 is join-receive and bit 1 is join-transmit. With 2'b10, transmit holds 8 words. Receive is disabled and reads full = 1, empty = 1, level = 0.
- R9: With 2'b01, receive holds 8 words. Transmit is disabled and reads full = 1, empty = 1, level = 0, so a bus push into it counts as overflow. The setting 2'b11 behaves as 2'b01.
- R10: Any change of `cfg_join` empties both queues. Pushes and pops offered in that cycle are dropped and set no flag. Turning join-receive on and then off again therefore acts as a flush.
- R11: `fifo_level[3:0]` carries the transmit fill count and `fifo_level[7:4]` carries the receive fill count.
- R12: `dreq_tx` is 1 exactly while transmit is not full. `dreq_rx` is 1 exactly while receive is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_join | input | 2 | Join setting: bit 0 join-receive, bit 1 join-transmit |
| bus_tx_push | input | 1 | Bus writes one word into transmit |
| bus_tx_data | input | 32 | Word written by the bus |
| bus_rx_pop | input | 1 | Bus takes the head word of receive |
| bus_rx_data | output | 32 | Head word of receive, 0 when empty |
| sh_tx_pull | input | 1 | Shifter takes the head word of transmit |
| sh_tx_data | output | 32 | Head word of transmit, 0 when empty |
| sh_rx_push | input | 1 | Shifter writes one word into receive |
| sh_rx_data | input | 32 | Word written by the shifter |
| tx_full | output | 1 | Transmit full |
| tx_empty | output | 1 | Transmit empty |
| rx_full | output | 1 | Receive full |
| rx_empty | output | 1 | Receive empty |
| fifo_level | output | 8 | {receive level, transmit level} |
| dbg_flags | output | 4 | Sticky flags: [0] tx stall, [1] tx overflow, [2] rx stall, [3] rx underflow |
| dbg_clr | input | 4 | Write-1-to-clear for `dbg_flags` |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |

## Verification
Some rules can be checked on every cycle. The assertions cover these:
- both queues are empty one cycle after any change of the join setting;
- a push into a full transmit queue leaves its level unchanged and raises the overflow flag;
- sticky flags never drop without a clear;
- an empty receive queue always presents zero;
- a transmit level above four always comes with a disabled receive side.

Other behaviour can only be shown by the bench's scenarios:
- first-in first-out ordering of words;
- the exact eight-word depth in each joined mode;
- the priority of join-receive when both bits are set;
- set-beats-clear on the flags;
- the double toggle used as a flush.

// File: rtl/fjp_pkg.sv
package fjp_pkg;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_TX_DEEP = 2'd1,
        MODE_RX_DEEP = 2'd2
    } join_mode_e;

    // bit 0 = join-receive (has priority), bit 1 = join-transmit
    function automatic join_mode_e decode_join(input logic [1:0] j);
        if (j[0])      return MODE_RX_DEEP;
        else if (j[1]) return MODE_TX_DEEP;
        else           return MODE_DUPLEX;
    endfunction

endpackage

// File: rtl/fjp_join_ctrl.sv
module fjp_join_ctrl
    import fjp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_join,
    output logic       flush,
    output logic       tx_en,
    output logic       rx_en,
    output logic       tx_joined,
    output logic       rx_joined
);

    join_mode_e mode_q;
    logic [1:0] join_q;

    // REJOIN when the setting differs from the registered copy, else STAY
    assign flush = (cfg_join != join_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DUPLEX;
            join_q <= 2'b00;
        end else if (flush) begin
            mode_q <= decode_join(cfg_join);
            join_q <= cfg_join;
        end
    end

    // outputs decoded from the state
    always_comb begin
        tx_en     = 1'b1;
        rx_en     = 1'b1;
        tx_joined = 1'b0;
        rx_joined = 1'b0;
        unique case (mode_q)
            MODE_DUPLEX: ;
            MODE_TX_DEEP: begin
                tx_joined = 1'b1;
                rx_en     = 1'b0;
            end
            MODE_RX_DEEP: begin
                rx_joined = 1'b1;
                tx_en     = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fjp_fifo_core.sv
module fjp_fifo_core #(
    parameter int W    = 32,
    parameter int HALF = 4,
    localparam int SLOTS = 2 * HALF,
    localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int LVLW  = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            enable,
    input  logic            joined,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic            full,
    output logic            empty,
    output logic [LVLW-1:0] level
);

    logic [W-1:0]    mem [SLOTS];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [LVLW-1:0] count;
    logic [LVLW-1:0] cap;
    logic            do_push, do_pop;

    assign cap     = joined ? LVLW'(SLOTS) : LVLW'(HALF);
    assign full    = !enable || (count == cap);
    assign empty   = !enable || (count == '0);
    assign level   = enable ? count : '0;
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + LVLW'(do_push) - LVLW'(do_pop);
        end
    end

endmodule

// File: rtl/fjp_err_flags.sv
module fjp_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    // a new event beats a clear of the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_ev;
    end

endmodule

// File: rtl/fifo_pair_join.sv
module fifo_pair_join #(
    parameter int W          = 32,
    parameter int HALF_DEPTH = 4,
    localparam int LVLW      = $clog2(2 * HALF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_join,
    input  logic              bus_tx_push,
    input  logic [W-1:0]      bus_tx_data,
    input  logic              bus_rx_pop,
    output logic [W-1:0]      bus_rx_data,
    input  logic              sh_tx_pull,
    output logic [W-1:0]      sh_tx_data,
    input  logic              sh_rx_push,
    input  logic [W-1:0]      sh_rx_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [2*LVLW-1:0] fifo_level,
    output logic [3:0]        dbg_flags,
    input  logic [3:0]        dbg_clr,
    output logic              dreq_tx,
    output logic              dreq_rx
);

    logic            flush, tx_en, rx_en, tx_joined, rx_joined;
    logic [LVLW-1:0] tx_lvl, rx_lvl;
    logic [3:0]      err_ev;

    fjp_join_ctrl u_join (
        .clk(clk), .rst_n(rst_n), .cfg_join(cfg_join), .flush(flush),
        .tx_en(tx_en), .rx_en(rx_en),
        .tx_joined(tx_joined), .rx_joined(rx_joined)
    );

    fjp_fifo_core #(.W(W), .HALF(HALF_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .enable(tx_en),
        .joined(tx_joined), .push(bus_tx_push), .push_data(bus_tx_data),
        .pop(sh_tx_pull), .head(sh_tx_data), .full(tx_full),
        .empty(tx_empty), .level(tx_lvl)
    );

    fjp_fifo_core #(.W(W), .HALF(HALF_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .enable(rx_en),
        .joined(rx_joined), .push(sh_rx_push), .push_data(sh_rx_data),
        .pop(bus_rx_pop), .head(bus_rx_data), .full(rx_full),
        .empty(rx_empty), .level(rx_lvl)
    );

    // error events; a flushing cycle drops traffic silently
    assign err_ev[0] = sh_tx_pull  && tx_empty && !flush;
    assign err_ev[1] = bus_tx_push && tx_full  && !flush;
    assign err_ev[2] = sh_rx_push  && rx_full  && !flush;
    assign err_ev[3] = bus_rx_pop  && rx_empty && !flush;

    fjp_err_flags #(.N(4)) u_err (
        .clk(clk), .rst_n(rst_n), .set_ev(err_ev), .clr(dbg_clr),
        .flags(dbg_flags)
    );

    assign fifo_level = {rx_lvl, tx_lvl};
    assign dreq_tx    = !tx_full;
    assign dreq_rx    = !rx_empty;

endmodule

// File: rtl/fjp_chk.sv
module fjp_chk #(
    parameter int W    = 32,
    parameter int HALF = 4,
    localparam int LVLW = $clog2(2 * HALF + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_join,
    input logic              bus_tx_push,
    input logic              sh_tx_pull,
    input logic [W-1:0]      bus_rx_data,
    input logic              tx_full,
    input logic              rx_full,
    input logic              rx_empty,
    input logic [2*LVLW-1:0] fifo_level,
    input logic [3:0]        dbg_flags,
    input logic [3:0]        dbg_clr
);

    logic [1:0] prev_join;
    always_ff @(posedge clk) begin
        if (!rst_n) prev_join <= 2'b00;
        else        prev_join <= cfg_join;
    end

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_join != prev_join) |=> (fifo_level == '0));

    assert_overflow_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_push && tx_full && cfg_join == prev_join) |=> dbg_flags[1]);

    assert_overflow_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_push && tx_full && !sh_tx_pull && cfg_join == prev_join)
        |=> $stable(fifo_level[LVLW-1:0]));

    assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (bus_rx_data == '0));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dbg_flags & $past(dbg_flags & ~dbg_clr)) == $past(dbg_flags & ~dbg_clr)));

    assert_deep_tx_disables_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level[LVLW-1:0] > LVLW'(HALF)) |-> (rx_full && rx_empty && fifo_level[2*LVLW-1:LVLW] == '0));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level[LVLW-1:0] <= LVLW'(2*HALF)) && (fifo_level[2*LVLW-1:LVLW] <= LVLW'(2*HALF)));

endmodule

bind fifo_pair_join fjp_chk #(.W(W), .HALF(HALF_DEPTH)) u_chk (.*);

// File: tb/fifo_pair_join_tb.sv
module fifo_pair_join_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_join = 2'b00;
    logic        bus_tx_push = 1'b0;
    logic [31:0] bus_tx_data = '0;
    logic        bus_rx_pop = 1'b0;
    logic [31:0] bus_rx_data;
    logic        sh_tx_pull = 1'b0;
    logic [31:0] sh_tx_data;
    logic        sh_rx_push = 1'b0;
    logic [31:0] sh_rx_data = '0;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]  fifo_level;
    logic [3:0]  dbg_flags;
    logic [3:0]  dbg_clr = '0;
    logic        dreq_tx, dreq_rx;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fifo_pair_join u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_push(input logic [31:0] d);
        bus_tx_push = 1'b1; bus_tx_data = d;
        tick();
        bus_tx_push = 1'b0;
    endtask

    task automatic sh_push(input logic [31:0] d);
        sh_rx_push = 1'b1; sh_rx_data = d;
        tick();
        sh_rx_push = 1'b0;
    endtask

    task automatic sh_pull(input string req, input logic [31:0] exp);
        sh_tx_pull = 1'b1;
        #1;
        chk(req, sh_tx_data, exp);
        tick();
        sh_tx_pull = 1'b0;
    endtask

    task automatic bus_pop(input string req, input logic [31:0] exp);
        bus_rx_pop = 1'b1;
        #1;
        chk(req, bus_rx_data, exp);
        tick();
        bus_rx_pop = 1'b0;
    endtask

    task automatic clear_flags();
        dbg_clr = 4'hF;
        tick();
        dbg_clr = 4'h0;
    endtask

    task automatic set_join(input logic [1:0] j);
        cfg_join = j;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 level", 32'(fifo_level), 0);
        chk("R1 flags", 32'(dbg_flags), 0);
        chk("R1 empties", {30'd0, tx_empty, rx_empty}, 32'd3);
        chk("R1 fulls", {30'd0, tx_full, rx_full}, 32'd0);
        chk("R1 dreq", {30'd0, dreq_tx, dreq_rx}, 32'd2);
    endtask

    task automatic t_duplex_order();
        for (int i = 0; i < 4; i++) bus_push(32'hA000 + i);
        chk("R2 tx full at 4", 32'(tx_full), 1);
        chk("R11 tx level", 32'(fifo_level), 32'h04);
        chk("R12 dreq_tx off when full", 32'(dreq_tx), 0);
        for (int i = 0; i < 4; i++) sh_pull("R2 tx order", 32'hA000 + i);
        chk("R2 tx empty", 32'(tx_empty), 1);
        for (int i = 0; i < 3; i++) sh_push(32'hB000 + i);
        chk("R11 rx level", 32'(fifo_level), 32'h30);
        chk("R12 dreq_rx on", 32'(dreq_rx), 1);
        for (int i = 0; i < 3; i++) bus_pop("R2 rx order", 32'hB000 + i);
        chk("R12 dreq_rx off", 32'(dreq_rx), 0);
    endtask

    task automatic t_tx_overflow();
        for (int i = 0; i < 5; i++) bus_push(32'hC000 + i);
        chk("R3 overflow flag", 32'(dbg_flags), 32'h2);
        chk("R3 level held", 32'(fifo_level), 32'h04);
        for (int i = 0; i < 4; i++) sh_pull("R3 discarded word absent", 32'hC000 + i);
        tick();
        chk("R7 flag sticky", 32'(dbg_flags), 32'h2);
        dbg_clr = 4'h2;
        tick();
        dbg_clr = 4'h0;
        chk("R7 cleared by write 1", 32'(dbg_flags), 0);
    endtask

    task automatic t_rx_underflow();
        chk("R4 empty reads 0", bus_rx_data, 0);
        bus_pop("R4 pop data", 0);
        chk("R4 underflow flag", 32'(dbg_flags), 32'h8);
        bus_rx_pop = 1'b1; dbg_clr = 4'h8;
        tick();
        bus_rx_pop = 1'b0; dbg_clr = 4'h0;
        chk("R7 set beats clear", 32'(dbg_flags), 32'h8);
        clear_flags();
        chk("R7 clear", 32'(dbg_flags), 0);
    endtask

    task automatic t_tx_stall();
        sh_pull("R5 empty pull data", 0);
        chk("R5 stall flag", 32'(dbg_flags), 32'h1);
        clear_flags();
    endtask

    task automatic t_rx_stall();
        for (int i = 0; i < 5; i++) sh_push(32'hD000 + i);
        chk("R6 stall flag", 32'(dbg_flags), 32'h4);
        chk("R6 level held", 32'(fifo_level), 32'h40);
        for (int i = 0; i < 4; i++) bus_pop("R6 discarded word absent", 32'hD000 + i);
        clear_flags();
    endtask

    task automatic t_tx_deep();
        set_join(2'b10);
        chk("R8 rx disabled", {29'd0, rx_full, rx_empty, dreq_rx}, 32'd6);
        for (int i = 0; i < 8; i++) bus_push(32'hE000 + i);
        chk("R8 tx level 8", 32'(fifo_level), 32'h08);
        chk("R8 tx full at 8", 32'(tx_full), 1);
        for (int i = 0; i < 8; i++) sh_pull("R8 deep order", 32'hE000 + i);
        chk("R8 no flags", 32'(dbg_flags), 0);
    endtask

    task automatic t_rx_deep();
        set_join(2'b01);
        chk("R9 tx disabled", {29'd0, tx_full, tx_empty, dreq_tx}, 32'd6);
        for (int i = 0; i < 8; i++) sh_push(32'hF000 + i);
        chk("R9 rx level 8", 32'(fifo_level), 32'h80);
        chk("R9 rx full at 8", 32'(rx_full), 1);
        bus_push(32'h1234);
        chk("R9 disabled tx push overflows", 32'(dbg_flags), 32'h2);
        clear_flags();
        set_join(2'b11);
        chk("R10 flushed on change", 32'(fifo_level), 0);
        for (int i = 0; i < 8; i++) sh_push(32'h5000 + i);
        chk("R9 both bits act as rx deep", 32'(fifo_level), 32'h80);
        chk("R9 both bits tx off", 32'(tx_full & tx_empty), 1);
        for (int i = 0; i < 8; i++) bus_pop("R9 deep order", 32'h5000 + i);
    endtask

    task automatic t_flush();
        set_join(2'b00);
        bus_push(32'h11); bus_push(32'h22);
        sh_push(32'h33); sh_push(32'h44);
        chk("R10 filled", 32'(fifo_level), 32'h22);
        cfg_join = 2'b01; bus_tx_push = 1'b1; bus_tx_data = 32'h99;
        tick();
        bus_tx_push = 1'b0;
        chk("R10 first toggle empties", 32'(fifo_level), 0);
        chk("R10 no flag in flush cycle", 32'(dbg_flags), 0);
        set_join(2'b00);
        chk("R10 second toggle stays empty", 32'(fifo_level), 0);
        chk("R10 duplex tx empty", 32'(tx_empty), 1);
        chk("R10 duplex tx not full", 32'(tx_full), 0);
        bus_push(32'h77);
        sh_pull("R10 dropped word absent", 32'h77);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_duplex_order();
        t_tx_overflow();
        t_rx_underflow();
        t_tx_stall();
        t_rx_stall();
        t_tx_deep();
        t_rx_deep();
        t_flush();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule